// File: doc/BRIEF.md
# Fully Associative Page Translation Table

This block turns a 64-bit virtual address into a 40-bit physical address using 4 KiB pages. Eight entries each record a virtual page number tag, a physical page number, a valid flag, a dirty flag and a recency rank. Every lookup compares its virtual page number against all entries in parallel. A hit returns the physical page number joined to the untouched 12-bit page offset. A miss, or a match on an invalid entry, reports a page fault. The compare is combinational and the result is registered, so the response appears one clock after the request. Walking tables in memory and moving pages are left to the surrounding system.

Only a privileged fill stream may install mappings. A fill whose page is already present rewrites that entry in place. Otherwise it takes the lowest-numbered free entry, or, when the table is full, the least recently used entry. Both hits and fills count as uses. When the chosen victim is dirty, the block first offers it on a write-back stream and holds the fill until that transfer is accepted. A store lookup that hits marks its entry dirty. An invalidate-all input empties the table in one cycle.

Stream rules: a fill transfers when `fill_valid` and `fill_ready` are both high at a clock edge. `fill_ready` may depend on the fill payload and on table state. It is low during invalidate. It is low for a privileged fill while a write-back is pending or still has to be raised. It is low when a same-cycle lookup hits the entry about to be evicted. A write-back transfers on `wb_valid && wb_ready`. Once raised, `wb_valid`, `wb_vpn` and `wb_ppn` hold steady until accepted. Lookups are always accepted and have no back-pressure.

Top module: `xlate_table`

## Requirements
- R1: A lookup that hits gives, one cycle after `lk_valid`, `rsp_valid`=1, `rsp_hit`=1, `rsp_fault`=0 and `rsp_paddr` = {stored 28-bit PPN, `lk_vaddr[11:0]`}.
- R2: A lookup whose VPN matches no valid entry gives, one cycle later, `rsp_valid`=1, `rsp_hit`=0, `rsp_fault`=1 and `rsp_paddr`=0.
- R3: The VPN is `lk_vaddr[47:12]`. Bits 63:48 do not affect the result.
- R4: A privileged fill installs VPN→PPN so that later lookups hit. A fill for a VPN already present replaces its PPN in place and leaves the other entries unchanged.
- R5: A fill with `fill_priv`=0 is accepted (`fill_ready`=1) but changes no entry, and `fill_err` is 1 for exactly the following cycle.
- R6: While a free entry exists, a fill evicts nothing and raises no write-back.
- R7: With the table full, a fill replaces the least recently used entry. Hits and fills each make their entry the most recently used.
- R8: A store lookup (`lk_store`=1) that hits marks the entry dirty. When a dirty entry is chosen for replacement, `wb_valid` rises with its VPN and PPN, and `fill_ready` stays 0 until the write-back has been accepted.
- R9: While `wb_valid`=1 and `wb_ready`=0, `wb_valid`, `wb_vpn` and `wb_ppn` stay unchanged.
- R10: A cycle with `inv_all`=1 clears every valid and dirty flag, so later lookups fault until new fills arrive.
- R11: After reset, `rsp_valid`, `wb_valid` and `fill_err` are 0 and every lookup faults.
- R12: Replacing a clean entry raises no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 64 | Virtual address to translate |
| lk_store | input | 1 | Lookup is a store; a hit marks the entry dirty |
| rsp_valid | output | 1 | Registered lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_fault | output | 1 | Page fault |
| rsp_paddr | output | 40 | Physical address on hit, else zero |
| fill_valid | input | 1 | Fill request valid |
| fill_ready | output | 1 | Fill accepted this cycle when valid |
| fill_priv | input | 1 | Fill issued with privilege |
| fill_vpn | input | 36 | Virtual page number to install |
| fill_ppn | input | 28 | Physical page number to install |
| fill_err | output | 1 | Pulse: previous fill rejected as illegal |
| wb_valid | output | 1 | Dirty victim offered for write-back |
| wb_ready | input | 1 | Write-back consumer ready |
| wb_vpn | output | 36 | VPN of the victim being written back |
| wb_ppn | output | 28 | PPN of the victim being written back |
| inv_all | input | 1 | Invalidate every entry |

## Verification
The hardest state to reach is a full table whose least recently used entry is dirty. Reaching it takes eight fills, a store hit on one chosen page, and then lookups that touch each of the other seven pages, so that the dirty page ends up oldest. A ninth fill then has to raise the write-back. The bench keeps `wb_ready` low for several cycles there. It checks that the offer holds steady and that the fill stalls, and afterwards that the dirty page alone was replaced. A clean eviction run just before this, after one re-touch, shows that hits reorder the recency.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  typedef enum logic [1:0] {
    SLOT_UPDATE = 2'd0,
    SLOT_FREE   = 2'd1,
    SLOT_EVICT  = 2'd2
  } slot_src_e;
endpackage

// File: rtl/xlt_pick.sv
module xlt_pick #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign found = |req;
endmodule

// File: rtl/xlt_cam.sv
module xlt_cam #(
  parameter int unsigned N     = 8,
  parameter int unsigned VPN_W = 36
) (
  input  logic [VPN_W-1:0]         key,
  input  logic [N-1:0][VPN_W-1:0]  tags,
  input  logic [N-1:0]             vld,
  output logic [N-1:0]             match
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld[g] && (tags[g] == key);
  end
endmodule

// File: rtl/xlt_lru.sv
module xlt_lru #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_en,
  input  logic [IW-1:0] a_idx,
  input  logic          b_en,
  input  logic [IW-1:0] b_idx,
  output logic [IW-1:0] victim
);
  typedef logic [N-1:0][IW-1:0] age_t;

  age_t age_q, age_d;
  logic [N-1:0] oldest;

  function automatic age_t bump(input age_t a, input logic [IW-1:0] k);
    age_t r;
    r = a;
    for (int i = 0; i < N; i++) begin
      if (a[i] < a[k]) r[i] = a[i] + 1'b1;
    end
    r[k] = '0;
    return r;
  endfunction

  always_comb begin
    age_d = age_q;
    if (a_en) age_d = bump(age_d, a_idx);
    if (b_en) age_d = bump(age_d, b_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else begin
      age_q <= age_d;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_old
    assign oldest[g] = (age_q[g] == IW'(N - 1));
  end

  xlt_pick #(.N(N)) u_pick_old (
    .req(oldest), .found(), .idx(victim)
  );

  AST_LRU_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(oldest)); // R7
  AST_LRU_TOUCHED_NOT_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && !b_en) |=> (victim != $past(a_idx))); // R7
endmodule

// File: rtl/xlate_table.sv
module xlate_table #(
  parameter int unsigned N     = 8,
  parameter int unsigned VA_W  = 64,
  parameter int unsigned PO_W  = 12,
  parameter int unsigned VPN_W = 36,
  parameter int unsigned PPN_W = 28,
  localparam int unsigned IW   = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned PA_W = PPN_W + PO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_store,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic             fill_priv,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  output logic             fill_err,
  output logic             wb_valid,
  input  logic             wb_ready,
  output logic [VPN_W-1:0] wb_vpn,
  output logic [PPN_W-1:0] wb_ppn,
  input  logic             inv_all
);
  import xlt_pkg::*;

  logic [N-1:0]             vld_q, dty_q;
  logic [N-1:0][VPN_W-1:0]  tag_q;
  logic [N-1:0][PPN_W-1:0]  ppn_q;

  logic [VPN_W-1:0] lk_vpn;
  logic [N-1:0]     m_lk, m_fl, free_vec;
  logic             lk_any, fl_any, free_any, lk_hit;
  logic [IW-1:0]    lk_idx, fl_idx, free_idx, vic_idx, tgt_idx;
  slot_src_e        slot_src;
  logic             need_wb, vic_busy, fill_fire, wb_raise, wb_take, store_hit;
  logic [IW-1:0]    wb_idx_q;
  logic             wb_redirty_q;
  logic             unused_hi;

  assign lk_vpn    = lk_vaddr[PO_W +: VPN_W];
  assign unused_hi = ^lk_vaddr[VA_W-1:PO_W+VPN_W];
  assign free_vec  = ~vld_q;

  xlt_cam #(.N(N), .VPN_W(VPN_W)) u_cam_lk (
    .key(lk_vpn), .tags(tag_q), .vld(vld_q), .match(m_lk)
  );
  xlt_cam #(.N(N), .VPN_W(VPN_W)) u_cam_fl (
    .key(fill_vpn), .tags(tag_q), .vld(vld_q), .match(m_fl)
  );
  xlt_pick #(.N(N)) u_pick_lk   (.req(m_lk),     .found(lk_any),   .idx(lk_idx));
  xlt_pick #(.N(N)) u_pick_fl   (.req(m_fl),     .found(fl_any),   .idx(fl_idx));
  xlt_pick #(.N(N)) u_pick_free (.req(free_vec), .found(free_any), .idx(free_idx));

  assign lk_hit    = lk_valid && lk_any;
  assign store_hit = lk_hit && lk_store;

  // Slot choice: same page first, then a free entry, then the oldest entry.
  always_comb begin
    if (fl_any) begin
      slot_src = SLOT_UPDATE;
      tgt_idx  = fl_idx;
    end else if (free_any) begin
      slot_src = SLOT_FREE;
      tgt_idx  = free_idx;
    end else begin
      slot_src = SLOT_EVICT;
      tgt_idx  = vic_idx;
    end
  end

  assign need_wb  = (slot_src == SLOT_EVICT) && dty_q[vic_idx];
  assign vic_busy = (slot_src == SLOT_EVICT) && lk_hit && (lk_idx == vic_idx);

  always_comb begin
    if (inv_all)        fill_ready = 1'b0;
    else if (!fill_priv) fill_ready = 1'b1;
    else                fill_ready = !wb_valid && !need_wb && !vic_busy;
  end

  assign fill_fire = fill_valid && fill_ready && fill_priv;
  assign wb_raise  = fill_valid && fill_priv && !inv_all && !wb_valid && need_wb;
  assign wb_take   = wb_valid && wb_ready;

  xlt_lru #(.N(N)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .a_en(lk_hit),    .a_idx(lk_idx),
    .b_en(fill_fire), .b_idx(tgt_idx),
    .victim(vic_idx)
  );

  // Entry storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dty_q <= '0;
      tag_q <= '0;
      ppn_q <= '0;
    end else begin
      if (wb_take && !wb_redirty_q && !(store_hit && lk_idx == wb_idx_q))
        dty_q[wb_idx_q] <= 1'b0;
      if (store_hit) dty_q[lk_idx] <= 1'b1;
      if (fill_fire) begin
        vld_q[tgt_idx] <= 1'b1;
        dty_q[tgt_idx] <= 1'b0;
        tag_q[tgt_idx] <= fill_vpn;
        ppn_q[tgt_idx] <= fill_ppn;
      end
      if (inv_all) begin
        vld_q <= '0;
        dty_q <= '0;
      end
    end
  end

  // Write-back offer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid     <= 1'b0;
      wb_vpn       <= '0;
      wb_ppn       <= '0;
      wb_idx_q     <= '0;
      wb_redirty_q <= 1'b0;
    end else if (wb_raise) begin
      wb_valid     <= 1'b1;
      wb_vpn       <= tag_q[vic_idx];
      wb_ppn       <= ppn_q[vic_idx];
      wb_idx_q     <= vic_idx;
      wb_redirty_q <= 1'b0;
    end else if (wb_valid) begin
      if (wb_take) wb_valid <= 1'b0;
      if (store_hit && lk_idx == wb_idx_q) wb_redirty_q <= 1'b1;
    end
  end

  // Lookup response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      fill_err  <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_hit;
      rsp_fault <= lk_valid && !lk_any;
      rsp_paddr <= lk_hit ? {ppn_q[lk_idx], lk_vaddr[PO_W-1:0]} : '0;
      fill_err  <= fill_valid && fill_ready && !fill_priv;
    end
  end

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (!rsp_hit || rsp_paddr[PO_W-1:0] == $past(lk_vaddr[PO_W-1:0]))); // R1
  AST_FAULT_ZERO_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_paddr == '0 && !rsp_hit && rsp_valid)); // R2
  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_lk)); // R4
  AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_priv) |=> $stable(tag_q)); // R5
  AST_FREE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_priv && free_any && !fl_any && !wb_valid) |=> !wb_valid); // R6
  AST_NO_DIRTY_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire && slot_src == SLOT_EVICT) |-> !dty_q[tgt_idx]); // R8
  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_vpn) && $stable(wb_ppn))); // R9
  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vld_q == '0 && dty_q == '0)); // R10
endmodule

// File: tb/xlate_table_tb_top.sv
`timescale 1ns/1ps
module xlate_table_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [63:0] lk_vaddr = '0;
  logic        lk_store = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [39:0] rsp_paddr;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic        fill_priv = 1'b0;
  logic [35:0] fill_vpn = '0;
  logic [27:0] fill_ppn = '0;
  logic        fill_err;
  logic        wb_valid;
  logic        wb_ready = 1'b1;
  logic [35:0] wb_vpn;
  logic [27:0] wb_ppn;
  logic        inv_all = 1'b0;

  int checks = 0;
  int failures = 0;
  int wb_count = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xlate_table dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_store(lk_store),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_priv(fill_priv),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_err(fill_err),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_vpn(wb_vpn), .wb_ppn(wb_ppn),
    .inv_all(inv_all)
  );

  always @(posedge clk) if (wb_valid && wb_ready) wb_count <= wb_count + 1;

  function automatic logic [35:0] pg(input int i);
    return 36'h8_0000_0000 + 36'(i * 37);
  endfunction
  function automatic logic [27:0] pp(input int i);
    return 28'h0A0_0000 + 28'(i * 5);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [35:0] vpn, input logic [11:0] off, input logic [15:0] hi,
                        input bit st, output bit hit, output logic [39:0] pa, output bit flt);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {hi, vpn, off}; lk_store = st;
    @(negedge clk);
    hit = rsp_hit && rsp_valid; pa = rsp_paddr; flt = rsp_fault;
    lk_valid = 1'b0; lk_store = 1'b0;
  endtask

  task automatic expect_hit(input string req, input int i, input logic [27:0] ppn);
    bit h, f; logic [39:0] pa;
    lookup(pg(i), 12'h5A3, 16'h0, 1'b0, h, pa, f);
    check(h && !f && pa == {ppn, 12'h5A3}, req, {h, f, pa}, {2'b10, ppn, 12'h5A3});
  endtask

  task automatic expect_fault(input string req, input int i);
    bit h, f; logic [39:0] pa;
    lookup(pg(i), 12'h0F0, 16'h0, 1'b0, h, pa, f);
    check(!h && f && pa == '0, req, {h, f, pa}, {2'b01, 40'h0});
  endtask

  task automatic fill(input logic [35:0] vpn, input logic [27:0] ppn, input bit priv);
    bit got;
    got = 1'b0;
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_priv = priv;
    for (int k = 0; k < 50 && !got; k++) begin
      #1;
      if (fill_ready) got = 1'b1;
      else @(negedge clk);
    end
    @(negedge clk);
    fill_valid = 1'b0; fill_priv = 1'b0;
    if (!got) check(1'b0, "R4 fill accept", 0, 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(!rsp_valid && !wb_valid && !fill_err, "R11 reset outputs",
          {rsp_valid, wb_valid, fill_err}, 0);
    expect_fault("R11 empty lookup faults", 3);
  endtask

  task automatic t_fill_free;
    int wb0;
    wb0 = wb_count;
    for (int i = 0; i < 8; i++) fill(pg(i), pp(i), 1'b1);
    check(wb_count == wb0 && !wb_valid, "R6 no write-back while free", wb_count, wb0);
    for (int i = 0; i < 8; i++) expect_hit("R1 hit after fill", i, pp(i));
    expect_fault("R2 unknown page faults", 20);
  endtask

  task automatic t_upper_bits;
    bit h, f; logic [39:0] pa;
    lookup(pg(4), 12'hFFF, 16'hBEEF, 1'b0, h, pa, f);
    check(h && pa == {pp(4), 12'hFFF}, "R3 upper bits ignored", pa, {pp(4), 12'hFFF});
  endtask

  task automatic t_illegal;
    fill(pg(30), pp(30), 1'b0);
    check(fill_err, "R5 fill_err pulse", fill_err, 1);
    @(negedge clk);
    check(!fill_err, "R5 fill_err one cycle", fill_err, 0);
    expect_fault("R5 rejected fill not installed", 30);
  endtask

  task automatic t_clean_evict;
    int wb0;
    // recency after fills and lookups above: page 0 oldest; touch it
    expect_hit("R7 touch page 0", 0, pp(0));
    wb0 = wb_count;
    fill(pg(8), pp(8), 1'b1);
    check(wb_count == wb0 && !wb_valid, "R12 clean victim no write-back", wb_count, wb0);
    expect_fault("R7 oldest page 1 replaced", 1);
    expect_hit("R7 touched page 0 kept", 0, pp(0));
    expect_hit("R7 new page 8 present", 8, pp(8));
  endtask

  task automatic t_dirty_evict;
    bit h, f; logic [39:0] pa;
    int order[7] = '{3, 5, 6, 7, 0, 8, 4};
    lookup(pg(2), 12'h001, 16'h0, 1'b1, h, pa, f);
    check(h, "R8 store hit", h, 1);
    foreach (order[k]) expect_hit("R7 touch", order[k], pp(order[k]));
    wb_ready = 1'b0;
    @(negedge clk);
    fill_valid = 1'b1; fill_priv = 1'b1; fill_vpn = pg(9); fill_ppn = pp(9);
    #1;
    check(!fill_ready, "R8 fill held for dirty victim", fill_ready, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(wb_valid && wb_vpn == pg(2) && wb_ppn == pp(2), "R9 write-back held steady",
            {wb_valid, wb_vpn, wb_ppn}, {1'b1, pg(2), pp(2)});
      check(!fill_ready, "R8 fill waits on write-back", fill_ready, 0);
    end
    wb_ready = 1'b1;
    @(negedge clk);
    check(!wb_valid, "R8 write-back accepted", wb_valid, 0);
    for (int k = 0; k < 5 && !fill_ready; k++) @(negedge clk);
    check(fill_ready, "R8 fill proceeds after write-back", fill_ready, 1);
    @(negedge clk);
    fill_valid = 1'b0; fill_priv = 1'b0;
    @(negedge clk);
    check(!wb_valid, "R8 single write-back", wb_valid, 0);
    expect_fault("R8 dirty page replaced", 2);
    expect_hit("R8 new page installed", 9, pp(9));
  endtask

  task automatic t_update_in_place;
    fill(pg(0), 28'h0FE_DCBA, 1'b1);
    expect_hit("R4 updated PPN", 0, 28'h0FE_DCBA);
    expect_hit("R4 other entry kept", 9, pp(9));
    expect_hit("R4 other entry kept", 3, pp(3));
  endtask

  task automatic t_invalidate;
    int wb0;
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
    expect_fault("R10 invalidated page 0", 0);
    expect_fault("R10 invalidated page 9", 9);
    wb0 = wb_count;
    for (int i = 40; i < 48; i++) fill(pg(i), pp(i), 1'b1);
    check(wb_count == wb0, "R6 refill after invalidate no write-back", wb_count, wb0);
    expect_hit("R10 refill works", 47, pp(47));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill_free();
    t_upper_bits();
    t_illegal();
    t_clean_evict();
    t_dirty_evict();
    t_update_in_place();
    t_invalidate();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule